// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a serial-bus slave that lets a host controller read and write an on-chip register file of up to 128 byte-wide locations. It watches the two bus lines on a system clock that is at least sixteen times faster than the serial clock. It finds START, repeated START and STOP conditions and answers one of two 7-bit bus addresses, chosen by a strap input. It pulls the data line low through an open-drain enable to acknowledge bytes and to return read data.

On the register side the block drives a plain register-bus port: an address, write data, a one-cycle write strobe and a one-cycle read strobe. The register file returns read data in the cycle the read strobe is high. An internal address counter is loaded from the register-address byte of a write transfer. After every data byte moved in either direction the counter steps by one when it lies inside a parameter-set window. Outside that window it keeps its value. The address space wraps from its last location back to 0x00. Random reads use a register-address write followed by a repeated START. Sequential reads and writes simply continue past the first byte.

Top module: `i2c_regslv`

## Requirements
- R1: After reset, sda_oe, reg_we and reg_re are all 0.
- R2: With addr_sel = 0 the slave answers 7-bit address 0x41 (bus bytes 0x82 write, 0x83 read), and with addr_sel = 1 it answers 0x44 (0x88 write, 0x89 read). On a match it drives SDA low (sda_oe = 1) during the ninth clock. The R/W bit is the last bit of the address byte, 1 meaning read.
- R3: On an address mismatch the slave gives no acknowledge, issues no register strobe and drives nothing until the next START.
- R4: Before any START, and after a STOP, clocked bytes on the bus are ignored: no acknowledge and no strobe.
- R5: In a write transfer the byte after the device address is the register address (its low 7 bits are used). Every following byte is acknowledged and produces one single-cycle reg_we pulse carrying that byte on reg_wdata and the counter value on reg_addr.
- R6: When the counter lies in the increment window INC_LO..INC_HI (default 0x40..0x7F), it advances by one after each data byte written or read.
- R7: When the counter lies outside the increment window (default 0x00..0x3F), every data byte uses the same address.
- R8: Stepping from the last address 0x7F gives 0x00.
- R9: A random read (register-address write, repeated START, device address with R) returns the register contents MSB first. reg_re is high for one system clock, and the first data bit appears on the bus in the next cycle. Each master ACK (SDA low on the ninth clock) fetches the next byte.
- R10: A master NACK (SDA high on the ninth clock) after a read byte ends the read. The slave releases SDA and ignores the bus until the next START.
- R11: sda_oe changes only while SCL is low.
- R12: reg_we and reg_re are never high in the same cycle, and neither is high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 1 | Strap selecting which of the two bus addresses is answered |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain), 0 releases it |
| reg_addr | output | AW (7) | Register-file address, from the internal counter |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Register-file read data, valid while reg_re is high |

## Verification
The hardest situation to reach from the ports is a counter step across the boundaries. These are the wrap from 0x7F to 0x00, and the point where the counter leaves the increment window and starts to hold. Both are seen only through the addresses a sequential transfer touches. The stimulus writes three bytes starting at 0x7E and then reads the same three back through a repeated START. The second byte must land at 0x7F and the third at 0x00. The stimulus also clocks whole bytes on the bus with no START, right after reset, after a STOP and after a read ended with NACK. It then checks that no acknowledge and no strobe follow.

// File: rtl/i2c_regslv_pkg.sv
package i2c_regslv_pkg;

    // Main transfer sequencer states
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD_LOAD,
        ST_RD,
        ST_RD_ACK
    } slv_state_e;

    // Filtered level of one bus line with its edges
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_evt_t;

    // Bus conditions derived from both filtered lines
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;
    localparam int N_LINES  = 2;

    // True when addr lies inside [lo, hi]
    function automatic logic in_window(input int unsigned addr,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (addr >= lo) && (addr <= hi);
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter
    import i2c_regslv_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      line_i,
    output line_evt_t evt
);
    localparam int MAJ = VOTE_TAPS / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   taps_q;
    logic                   level_q;
    logic                   prev_q;
    logic                   vote;

    always_comb begin
        vote = ($countones(taps_q) > MAJ);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            taps_q  <= '1;
            level_q <= 1'b1;
            prev_q  <= 1'b1;
        end else begin
            sync_q  <= {sync_q[SYNC_STAGES-2:0], line_i};
            taps_q  <= {taps_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
            level_q <= vote;
            prev_q  <= level_q;
        end
    end

    always_comb begin
        evt.level = level_q;
        evt.rise  = level_q & ~prev_q;
        evt.fall  = ~level_q & prev_q;
    end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_regslv_pkg::*;
(
    input  line_evt_t scl,
    input  line_evt_t sda,
    output bus_evt_t  evt
);
    // SCL must have been high in the previous sample as well, so an SDA
    // edge that coincides with an SCL edge is not taken as a condition.
    logic scl_steady_high;

    always_comb begin
        scl_steady_high = scl.level & ~scl.rise;
        evt.start    = sda.fall & scl_steady_high;
        evt.stop     = sda.rise & scl_steady_high;
        evt.scl_rise = scl.rise;
        evt.scl_fall = scl.fall;
        evt.sda      = sda.level;
    end
endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr
    import i2c_regslv_pkg::*;
#(
    parameter int AW     = 7,
    parameter int INC_LO = 'h40,
    parameter int INC_HI = 'h7F
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] stepped;
    logic          inc_ok;

    always_comb begin
        inc_ok  = in_window(int'(addr_q), INC_LO, INC_HI);
        // The sum is truncated to AW bits, so the last address wraps to zero
        stepped = inc_ok ? addr_q + 1'b1 : addr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (step) begin
            addr_q <= stepped;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/i2c_regslv.sv
module i2c_regslv
    import i2c_regslv_pkg::*;
#(
    parameter int       AW          = 7,
    parameter int       DW          = 8,
    parameter int       INC_LO      = 'h40,
    parameter int       INC_HI      = 'h7F,
    parameter int       SYNC_STAGES = 2,
    parameter int       VOTE_TAPS   = 3,
    parameter bit [6:0] DEV_ADDR0   = 7'h41,
    parameter bit [6:0] DEV_ADDR1   = 7'h44
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_sel,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    input  logic [DW-1:0] reg_rdata
);
    localparam int CNT_W = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW);

    // ---------------------------------------------------------------
    // Line conditioning, one filter per bus line
    // ---------------------------------------------------------------
    logic [N_LINES-1:0] raw_lines;
    line_evt_t          line_evt [N_LINES];
    bus_evt_t           ev;

    assign raw_lines[LINE_SCL] = scl_i;
    assign raw_lines[LINE_SDA] = sda_i;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2c_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .VOTE_TAPS  (VOTE_TAPS)
        ) u_filt (
            .clk   (clk),
            .rst   (rst),
            .line_i(raw_lines[g]),
            .evt   (line_evt[g])
        );
    end

    i2c_bus_events u_events (
        .scl(line_evt[LINE_SCL]),
        .sda(line_evt[LINE_SDA]),
        .evt(ev)
    );

    // ---------------------------------------------------------------
    // Sequencer
    // ---------------------------------------------------------------
    slv_state_e      state_q;
    logic [CNT_W-1:0] bit_cnt_q;
    logic [DW-1:0]   shreg_q;
    logic            rw_q;
    logic            mack_q;
    logic            oe_q;
    logic            we_q;
    logic            re_q;
    logic            ld_q;
    logic [DW-1:0]   wdata_q;
    logic [AW-1:0]   ld_val_q;
    logic [6:0]      my_addr;
    logic            rx_state;
    logic            byte_done;

    always_comb begin
        my_addr   = addr_sel ? DEV_ADDR1 : DEV_ADDR0;
        rx_state  = (state_q == ST_DEV) || (state_q == ST_REG) || (state_q == ST_WR);
        byte_done = ev.scl_fall && (bit_cnt_q == LAST_BIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            oe_q      <= 1'b0;
            we_q      <= 1'b0;
            re_q      <= 1'b0;
            ld_q      <= 1'b0;
            wdata_q   <= '0;
            ld_val_q  <= '0;
        end else begin
            we_q <= 1'b0;
            re_q <= 1'b0;
            ld_q <= 1'b0;
            if (ev.stop) begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
            end else if (ev.start) begin
                state_q   <= ST_DEV;
                bit_cnt_q <= '0;
                oe_q      <= 1'b0;
            end else if (rx_state) begin
                if (ev.scl_rise) begin
                    shreg_q   <= {shreg_q[DW-2:0], ev.sda};
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end else if (byte_done) begin
                    bit_cnt_q <= '0;
                    unique case (state_q)
                        ST_DEV: begin
                            if (shreg_q[7:1] == my_addr) begin
                                oe_q    <= 1'b1;
                                rw_q    <= shreg_q[0];
                                state_q <= ST_DEV_ACK;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                        ST_REG: begin
                            ld_q     <= 1'b1;
                            ld_val_q <= shreg_q[AW-1:0];
                            oe_q     <= 1'b1;
                            state_q  <= ST_REG_ACK;
                        end
                        default: begin
                            we_q    <= 1'b1;
                            wdata_q <= shreg_q;
                            oe_q    <= 1'b1;
                            state_q <= ST_WR_ACK;
                        end
                    endcase
                end
            end else begin
                unique case (state_q)
                    ST_DEV_ACK: begin
                        if (ev.scl_fall) begin
                            oe_q <= 1'b0;
                            if (rw_q) begin
                                re_q    <= 1'b1;
                                state_q <= ST_RD_LOAD;
                            end else begin
                                state_q <= ST_REG;
                            end
                        end
                    end
                    ST_REG_ACK, ST_WR_ACK: begin
                        if (ev.scl_fall) begin
                            oe_q    <= 1'b0;
                            state_q <= ST_WR;
                        end
                    end
                    ST_RD_LOAD: begin
                        // reg_re is high in this cycle; capture the byte and
                        // present its MSB on the bus
                        shreg_q   <= reg_rdata;
                        oe_q      <= ~reg_rdata[DW-1];
                        bit_cnt_q <= '0;
                        state_q   <= ST_RD;
                    end
                    ST_RD: begin
                        if (ev.scl_rise) begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end else if (byte_done) begin
                            oe_q    <= 1'b0;
                            state_q <= ST_RD_ACK;
                        end else if (ev.scl_fall) begin
                            shreg_q <= {shreg_q[DW-2:0], 1'b0};
                            oe_q    <= ~shreg_q[DW-2];
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_rise) begin
                            mack_q <= ~ev.sda;
                            if (ev.sda) begin
                                state_q <= ST_IDLE;
                            end
                        end else if (ev.scl_fall && mack_q) begin
                            re_q    <= 1'b1;
                            state_q <= ST_RD_LOAD;
                        end
                    end
                    default: begin
                        oe_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    // ---------------------------------------------------------------
    // Address counter: steps once after each strobe
    // ---------------------------------------------------------------
    i2c_addr_ctr #(
        .AW    (AW),
        .INC_LO(INC_LO),
        .INC_HI(INC_HI)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .load    (ld_q),
        .load_val(ld_val_q),
        .step    (we_q | re_q),
        .addr    (reg_addr)
    );

    assign sda_oe    = oe_q;
    assign reg_we    = we_q;
    assign reg_re    = re_q;
    assign reg_wdata = wdata_q;
endmodule

// File: rtl/i2c_regslv_chk.sv
module i2c_regslv_chk #(
    parameter int AW     = 7,
    parameter int DW     = 8,
    parameter int INC_LO = 'h40,
    parameter int INC_HI = 'h7F
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_i,
    input logic          sda_oe,
    input logic          reg_we,
    input logic          reg_re,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_rdata
);
    logic in_range;
    assign in_range = (int'(reg_addr) >= INC_LO) && (int'(reg_addr) <= INC_HI);

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_i);                                   // R11

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_re));                                           // R12

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);                                            // R12

    AST_RE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> !reg_re);                                            // R12

    AST_RE_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> (sda_oe == !$past(reg_rdata[DW-1])));                // R9

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (reg_we || reg_re) && in_range |=> (reg_addr == AW'($past(reg_addr) + 1'b1))); // R6

    AST_CTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (reg_we || reg_re) && !in_range |=> $stable(reg_addr));         // R7
endmodule

bind i2c_regslv i2c_regslv_chk #(
    .AW    (AW),
    .DW    (DW),
    .INC_LO(INC_LO),
    .INC_HI(INC_HI)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata)
);

// File: tb/i2c_regslv_bench.sv
module i2c_regslv_bench;
    localparam int QT      = 24;      // system clocks per quarter SCL bit
    localparam int AW      = 7;
    localparam int DEPTH   = 1 << AW;
    localparam int WIN_LO  = 'h40;
    localparam int WIN_HI  = 'h7F;

    typedef struct {
        logic [6:0] a;
        logic [7:0] d;
    } wr_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic addr_sel = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_bus;
    logic sda_oe;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic reg_we, reg_re;
    logic [7:0] reg_rdata;

    logic [7:0] mem [DEPTH];
    logic [7:0] exp_mem [DEPTH];
    wr_item_t wq[$];

    int checks = 0, fails = 0;
    int mon_checks = 0, mon_fails = 0;
    int viol_r11 = 0, viol_r12 = 0;
    logic prev_oe = 1'b0, prev_we = 1'b0, prev_re = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus   = m_sda & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    i2c_regslv u_i2c_regslv (
        .clk      (clk),
        .rst      (rst),
        .addr_sel (addr_sel),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .reg_re   (reg_re),
        .reg_rdata(reg_rdata)
    );

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
    end

    // Register file and scoreboard monitor
    always @(posedge clk) begin
        if (!rst) begin
            if (reg_we) begin
                mem[reg_addr] <= reg_wdata;
                mon_checks++;
                if (wq.size() == 0) begin
                    mon_fails++;
                    $display("FAIL R3/R4/R5: unexpected write addr=%h data=%h, expected none",
                             reg_addr, reg_wdata);
                end else begin
                    wr_item_t e;
                    e = wq.pop_front();
                    if (reg_addr != e.a || reg_wdata != e.d) begin
                        mon_fails++;
                        $display("FAIL R5/R6/R7/R8: write addr=%h data=%h, expected addr=%h data=%h",
                                 reg_addr, reg_wdata, e.a, e.d);
                    end
                end
            end
            if (sda_oe != prev_oe && m_scl) viol_r11++;
            if ((reg_we && reg_re) || (reg_we && prev_we) || (reg_re && prev_re)) viol_r12++;
            prev_oe <= sda_oe;
            prev_we <= reg_we;
            prev_re <= reg_re;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] nxt(input logic [6:0] a);
        if (int'(a) >= WIN_LO && int'(a) <= WIN_HI) return a + 7'd1;
        return a;
    endfunction

    task automatic q();
        repeat (QT) @(negedge clk);
    endtask

    task automatic put_bit(input logic b, output logic smp);
        m_sda = b;
        q();
        m_scl = 1'b1;
        q();
        smp = sda_bus;
        q();
        m_scl = 1'b0;
        q();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic d;
        for (int i = 7; i >= 0; i--) put_bit(v[i], d);
        put_bit(1'b1, ack);
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] v);
        logic d;
        for (int i = 7; i >= 0; i--) put_bit(1'b1, v[i]);
        put_bit(~master_ack, d);
    endtask

    task automatic bstart();
        if (!m_scl) begin
            m_sda = 1'b1;
            q();
            m_scl = 1'b1;
            q();
        end
        m_sda = 1'b0;
        q();
        m_scl = 1'b0;
        q();
    endtask

    task automatic bstop();
        m_sda = 1'b0;
        q();
        m_scl = 1'b1;
        q();
        m_sda = 1'b1;
        q();
        q();
    endtask

    task automatic wr_xfer(input logic [6:0] dev, input logic matched, input logic [6:0] ra,
                           input int n, input logic [7:0] seed, input string tag);
        logic ack;
        logic [6:0] a;
        logic [7:0] d;
        a = ra;
        bstart();
        send_byte({dev, 1'b0}, ack);
        chk(ack == !matched, tag, ack, !matched);
        send_byte({1'b0, ra}, ack);
        chk(ack == !matched, tag, ack, !matched);
        for (int k = 0; k < n; k++) begin
            d = seed + 8'(k * 29);
            if (matched) begin
                wq.push_back('{a, d});
                exp_mem[a] = d;
                a = nxt(a);
            end
            send_byte(d, ack);
            chk(ack == !matched, tag, ack, !matched);
        end
        bstop();
    endtask

    task automatic rd_xfer(input logic [6:0] dev, input logic [6:0] ra, input int n,
                           input logic do_stop, input string tag);
        logic ack;
        logic [6:0] a;
        logic [7:0] v;
        a = ra;
        bstart();
        send_byte({dev, 1'b0}, ack);
        chk(ack == 1'b0, tag, ack, 0);
        send_byte({1'b0, ra}, ack);
        chk(ack == 1'b0, tag, ack, 0);
        bstart();
        send_byte({dev, 1'b1}, ack);
        chk(ack == 1'b0, tag, ack, 0);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, v);
            chk(v == exp_mem[a], tag, v, exp_mem[a]);
            a = nxt(a);
        end
        if (do_stop) bstop();
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks + mon_checks - fails - mon_fails,
                 checks + mon_checks + 1);
        $finish;
    end

    initial begin
        logic ack;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        chk(reg_we == 1'b0, "R1 reg_we", reg_we, 0);
        chk(reg_re == 1'b0, "R1 reg_re", reg_re, 0);

        // R4: a matching address byte clocked without any START
        m_scl = 1'b0;
        q();
        send_byte(8'h82, ack);
        chk(ack == 1'b1, "R4 no START", ack, 1);
        send_byte(8'h10, ack);
        chk(ack == 1'b1, "R4 no START data", ack, 1);

        // R5 R6: sequential write in the increment window
        wr_xfer(7'h41, 1'b1, 7'h42, 3, 8'h5A, "R5 R6 write 0x42");
        // R7: hold outside the window
        wr_xfer(7'h41, 1'b1, 7'h10, 2, 8'hC3, "R7 write hold 0x10");
        // R8: rollover
        wr_xfer(7'h41, 1'b1, 7'h7E, 3, 8'h11, "R8 write wrap 0x7E");
        // R3: wrong device address
        wr_xfer(7'h44, 1'b0, 7'h20, 2, 8'hEE, "R3 mismatch");

        // R4: bytes after a STOP are ignored
        m_scl = 1'b0;
        q();
        send_byte(8'h82, ack);
        chk(ack == 1'b1, "R4 after STOP", ack, 1);
        send_byte(8'h33, ack);
        chk(ack == 1'b1, "R4 after STOP data", ack, 1);

        // R9 R6: random and sequential read
        rd_xfer(7'h41, 7'h42, 3, 1'b1, "R9 R6 read 0x42");
        rd_xfer(7'h41, 7'h10, 2, 1'b1, "R9 R7 read hold 0x10");
        rd_xfer(7'h41, 7'h7E, 3, 1'b1, "R9 R8 read wrap 0x7E");

        // R10: after NACK the slave is idle; no STOP, raw byte is ignored
        rd_xfer(7'h41, 7'h05, 1, 1'b0, "R10 read one");
        chk(sda_oe == 1'b0, "R10 released", sda_oe, 0);
        send_byte(8'h82, ack);
        chk(ack == 1'b1, "R10 idle after NACK", ack, 1);
        bstop();

        // R2: strap selects the other address
        addr_sel = 1'b1;
        wr_xfer(7'h44, 1'b1, 7'h30, 1, 8'h77, "R2 strap1 write");
        wr_xfer(7'h41, 1'b0, 7'h31, 1, 8'h88, "R2 strap1 old addr");
        rd_xfer(7'h44, 7'h30, 1, 1'b1, "R2 strap1 read");
        addr_sel = 1'b0;
        wr_xfer(7'h41, 1'b1, 7'h08, 1, 8'h9C, "R2 strap0 write");

        repeat (20) @(negedge clk);
        chk(wq.size() == 0, "R5 all writes seen", wq.size(), 0);
        chk(viol_r11 == 0, "R11 oe only while SCL low", viol_r11, 0);
        chk(viol_r12 == 0, "R12 strobe pulses", viol_r12, 0);

        $display("%0d/%0d checks passed", checks + mon_checks - fails - mon_fails,
                 checks + mon_checks);
        $finish;
    end
endmodule